// File: doc/BRIEF.md
# Turbo Rate-Matching Sub-Block Interleaver

This block reorders one coded output stream of a turbo encoder before bit collection. It takes a block of D bits, one bit per cycle, and fills a matrix of 32 columns row by row. If D is not a multiple of 32, the start of the first row is filled with NULL padding. The block then reads the matrix out column by column, with the columns visited in bit-reversed order. Padding positions are dropped, so exactly D bits leave the block.

A one-bit selector picks the read mapping. Setting 0 is the plain column-permuted read used for the systematic stream and the first parity stream. Setting 1 adds one to every read position, wrapping over the whole matrix, as used for the second parity stream.

A start pulse latches D and the selector. The bits then arrive under a valid/ready handshake. After the last input bit is taken, the block drains the matrix and cannot accept a new block until the drain is complete.

Top module: `subblk_ilv`

## Requirements
- R1: For a block of length D, the row count is R = ceil(D/32) and the padding count is ND = 32R − D. Input bit i (counting from 0) is stored at matrix position ND + i, which is row (ND+i)/32 and column (ND+i) mod 32.
- R2: A `start` pulse is taken only when `busy` is low and 1 ≤ `blk_len` ≤ MAX_LEN (default 6144). Any other `start` has no effect: `busy` and `in_ready` stay low.
- R3: `in_ready` goes high in the cycle after an accepted start. It stays high until exactly D bits have been accepted, and is low at all other times. A bit is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- R4: With `third_stream` = 0, output index k (0 ≤ k < 32R) reads matrix position P(⌊k/R⌋) + 32·(k mod R). P(j) is the 5-bit bit-reversal of j, so P(1) = 16 and P(3) = 24.
- R5: With `third_stream` = 1, output index k reads position (P(⌊k/R⌋) + 32·(k mod R) + 1) mod 32R.
- R6: A position below ND is never emitted. Each block produces exactly D cycles with `out_valid` high, at most one bit per cycle, in increasing k order. `out_valid` stays low when no block is being read out.
- R7: `out_last` is high in the cycle that carries the D-th output bit of a block, and low in every other cycle.
- R8: A `start` while `busy` is high is ignored, and the running block completes with its own length and selector. `busy` falls once the read-out has been issued, and a new start is accepted from then on.
- R9: During and right after reset, `in_ready`, `busy`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a block; latches `blk_len` and `third_stream` |
| blk_len | input | LEN_W | Block length D in bits |
| third_stream | input | 1 | 0: plain permuted read; 1: read shifted by one position |
| in_valid | input | 1 | Input bit present |
| in_bit | input | 1 | Input data bit |
| in_ready | output | 1 | Block is collecting input bits |
| busy | output | 1 | A block is being loaded or read out |
| out_valid | output | 1 | `out_bit` carries an interleaved bit |
| out_bit | output | 1 | Interleaved data bit |
| out_last | output | 1 | Marks the final bit of the block |

## Verification
The bench runs blocks whose lengths cover several cases:
- D = 32 and 64 have no padding. These separate the column order from the padding logic.
- D = 1, 17, 33, 40 and 100 have partial first rows. These show whether the padding positions are found correctly after the permutation.
- D = 17 and 1 have a single row. In the shifted mode this makes the wrap fall inside the first row.
- D = 6144 with both selector settings checks the full-size buffer and the wrap from the last position back to position 0.

Input gaps and start pulses made during loading and during read-out show that the handshake and the latched settings hold. Out-of-range lengths show that invalid starts are dropped.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

  localparam int NCOL   = 32;
  localparam int NCOL_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_DRAIN} phase_t;

  // column visited at output slot j: bit-reversed slot number
  function automatic logic [NCOL_W-1:0] col_perm(input logic [NCOL_W-1:0] j);
    return {j[0], j[1], j[2], j[3], j[4]};
  endfunction

  function automatic int rows_for(input int len);
    return (len + NCOL - 1) / NCOL;
  endfunction

  function automatic int pad_for(input int len);
    return rows_for(len) * NCOL - len;
  endfunction

  // matrix position read for permuted column pc, row r
  function automatic int src_index(input int pc, input int r, input int rows,
                                   input logic shift);
    int p;
    p = pc + NCOL * r + (shift ? 1 : 0);
    if (p >= rows * NCOL) p = p - rows * NCOL;
    return p;
  endfunction

endpackage

// File: rtl/sbi_ctrl.sv
module sbi_ctrl
  import sbi_pkg::*;
#(
  parameter int MAX_LEN = 6144,
  parameter int LEN_W   = 13,
  parameter int ROW_W   = 8,
  parameter int POS_W   = ROW_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             third_stream,
  input  logic             in_valid,
  input  logic             rd_done,
  output logic             start_ok,
  output logic             in_ready,
  output logic             busy,
  output logic             wr_en,
  output logic [POS_W-1:0] wr_pos,
  output logic             rd_run,
  output logic [LEN_W-1:0] cfg_len,
  output logic [ROW_W-1:0] cfg_rows,
  output logic [4:0]       cfg_nd,
  output logic             cfg_shift
);

  phase_t           ph;
  logic [LEN_W-1:0] ld_cnt;
  logic             ld_final;

  assign start_ok = (ph == PH_IDLE) && start && (blk_len != '0)
                    && (int'(blk_len) <= MAX_LEN);
  assign in_ready = (ph == PH_LOAD);
  assign wr_en    = in_valid && (ph == PH_LOAD);
  assign rd_run   = (ph == PH_DRAIN);
  assign busy     = (ph != PH_IDLE);
  assign ld_final = wr_en && (ld_cnt == cfg_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      ld_cnt    <= '0;
      wr_pos    <= '0;
      cfg_len   <= '0;
      cfg_rows  <= '0;
      cfg_nd    <= '0;
      cfg_shift <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start_ok) begin
          cfg_len   <= blk_len;
          cfg_rows  <= ROW_W'(rows_for(int'(blk_len)));
          cfg_nd    <= 5'(pad_for(int'(blk_len)));
          cfg_shift <= third_stream;
          wr_pos    <= POS_W'(pad_for(int'(blk_len)));
          ld_cnt    <= '0;
          ph        <= PH_LOAD;
        end
        PH_LOAD: if (wr_en) begin
          wr_pos <= wr_pos + POS_W'(1);
          ld_cnt <= ld_cnt + LEN_W'(1);
          if (ld_final) ph <= PH_DRAIN;
        end
        PH_DRAIN: if (rd_done) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_WR_ABOVE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_pos >= POS_W'(cfg_nd)) && (wr_pos < {cfg_rows, 5'b0})); // R1

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_run && $past(in_ready)) |-> (wr_pos == {cfg_rows, 5'b0})); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cfg_len) && $stable(cfg_shift))); // R8

endmodule

// File: rtl/sbi_rd_agu.sv
module sbi_rd_agu
  import sbi_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int POS_W = ROW_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [4:0]       cfg_nd,
  input  logic             cfg_shift,
  output logic [POS_W-1:0] rd_pos,
  output logic             rd_null,
  output logic             rd_done
);

  logic [4:0]       col_q;
  logic [ROW_W-1:0] row_q;
  logic             row_end;

  assign row_end = (row_q == cfg_rows - ROW_W'(1));
  assign rd_done = run && (col_q == 5'd31) && row_end;
  assign rd_pos  = POS_W'(src_index(int'(col_perm(col_q)), int'(row_q),
                                    int'(cfg_rows), cfg_shift));
  assign rd_null = (rd_pos < POS_W'(cfg_nd));

  // column slot outer, row inner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (!run) begin
      col_q <= '0;
      row_q <= '0;
    end else if (row_end) begin
      row_q <= '0;
      col_q <= col_q + 5'd1;
    end else begin
      row_q <= row_q + ROW_W'(1);
    end
  end

  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rd_pos < {cfg_rows, 5'b0})); // R5

endmodule

// File: rtl/sbi_store.sv
module sbi_store #(
  parameter int ROWS_MAX = 192,
  parameter int ROW_W    = 8,
  parameter int POS_W    = ROW_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             wr_bit,
  input  logic             rd_en,
  input  logic [POS_W-1:0] rd_pos,
  output logic             out_valid,
  output logic             out_bit
);

  logic [31:0] mem [ROWS_MAX];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_pos[POS_W-1:5]][wr_pos[4:0]] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= rd_en;
      out_bit   <= rd_en ? mem[rd_pos[POS_W-1:5]][rd_pos[4:0]] : 1'b0;
    end
  end

endmodule

// File: rtl/subblk_ilv.sv
module subblk_ilv #(
  parameter int MAX_LEN = 6144,
  localparam int ROWS_MAX = (MAX_LEN + 31) / 32,
  localparam int ROW_W    = $clog2(ROWS_MAX + 1),
  localparam int POS_W    = ROW_W + 5,
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             third_stream,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             busy,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_last
);

  logic             start_ok, wr_en, rd_run, rd_null, rd_done, cfg_shift;
  logic [POS_W-1:0] wr_pos, rd_pos;
  logic [LEN_W-1:0] cfg_len, emit_cnt;
  logic [ROW_W-1:0] cfg_rows;
  logic [4:0]       cfg_nd;
  logic             rd_fetch;

  sbi_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ROW_W(ROW_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .third_stream(third_stream), .in_valid(in_valid), .rd_done(rd_done),
    .start_ok(start_ok), .in_ready(in_ready), .busy(busy), .wr_en(wr_en),
    .wr_pos(wr_pos), .rd_run(rd_run), .cfg_len(cfg_len), .cfg_rows(cfg_rows),
    .cfg_nd(cfg_nd), .cfg_shift(cfg_shift)
  );

  sbi_rd_agu #(.ROW_W(ROW_W), .POS_W(POS_W)) u_agu (
    .clk(clk), .rst_n(rst_n), .run(rd_run), .cfg_rows(cfg_rows),
    .cfg_nd(cfg_nd), .cfg_shift(cfg_shift), .rd_pos(rd_pos),
    .rd_null(rd_null), .rd_done(rd_done)
  );

  assign rd_fetch = rd_run && !rd_null;

  sbi_store #(.ROWS_MAX(ROWS_MAX), .ROW_W(ROW_W), .POS_W(POS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pos(wr_pos), .wr_bit(in_bit),
    .rd_en(rd_fetch), .rd_pos(rd_pos), .out_valid(out_valid), .out_bit(out_bit)
  );

  // counts emitted bits of the current block for the final-bit flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         emit_cnt <= '0;
    else if (start_ok)  emit_cnt <= '0;
    else if (out_valid) emit_cnt <= emit_cnt + LEN_W'(1);
  end

  assign out_last = out_valid && (emit_cnt == cfg_len - LEN_W'(1));

  AST_EMIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (emit_cnt < cfg_len)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !out_valid); // R6

endmodule

// File: tb/subblk_ilv_test.sv
module subblk_ilv_test;

  localparam int MAXL = 6144;
  localparam int LW   = $clog2(MAXL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic          third_stream = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_bit = 1'b0;
  logic          in_ready, busy, out_valid, out_bit, out_last;

  always #10 clk = ~clk;

  subblk_ilv #(.MAX_LEN(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .third_stream(third_stream), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .busy(busy), .out_valid(out_valid),
    .out_bit(out_bit), .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int unsigned seed = 32'h1234_5678;
  bit exp_bit_q[$];
  bit exp_last_q[$];

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  // output monitor against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_bit_q.size() == 0) begin
          check(1'b0, "R6", "output beyond block", 1, 0);
        end else begin
          bit eb, el;
          eb = exp_bit_q.pop_front();
          el = exp_last_q.pop_front();
          check(out_bit == eb, "R4/R5", "out_bit", int'(out_bit), int'(eb));
          check(out_last == el, "R7", "out_last", int'(out_last), int'(el));
        end
      end else if (out_last) begin
        check(1'b0, "R7", "out_last without out_valid", 1, 0);
      end
    end
  end

  function automatic int rev5(int j);
    int p = 0;
    for (int b = 0; b < 5; b++) if ((j >> b) & 1) p += 1 << (4 - b);
    return p;
  endfunction

  task automatic try_bad(int len);
    @(negedge clk);
    start = 1'b1; blk_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R2", "busy after bad start", int'(busy), 0);
    check(in_ready == 1'b0, "R2", "in_ready after bad start", int'(in_ready), 0);
  endtask

  task automatic run_block(int len, bit sel, int gap_mod, bit poke);
    int rows, nd, cnt;
    bit data[];
    rows = 0;
    while (rows * 32 < len) rows++;
    nd = rows * 32 - len;
    data = new[len];
    for (int i = 0; i < len; i++) begin
      seed = seed * 1103515245 + 12345;
      data[i] = seed[16];
    end
    cnt = 0;
    for (int k = 0; k < rows * 32; k++) begin
      int p;
      p = (rev5(k / rows) + 32 * (k % rows) + (sel ? 1 : 0)) % (rows * 32);
      if (p >= nd) begin
        exp_bit_q.push_back(data[p - nd]);
        exp_last_q.push_back(cnt == len - 1);
        cnt++;
      end
    end
    @(negedge clk);
    start = 1'b1; blk_len = LW'(len); third_stream = sel;
    @(negedge clk);
    start = 1'b0; third_stream = ~sel;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    check(in_ready == 1'b1, "R3", "in_ready after start", int'(in_ready), 1);
    for (int i = 0; i < len; i++) begin
      bit acc;
      if (gap_mod != 0 && (i % gap_mod) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_bit = data[i];
      if (poke && i == len / 2) begin
        start = 1'b1; blk_len = LW'(5);   // R8 start during load
      end
      do begin
        acc = in_ready;
        @(negedge clk);
        start = 1'b0;
      end while (!acc);
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R3", "in_ready after D bits", int'(in_ready), 0);
    if (poke) begin
      start = 1'b1; blk_len = LW'(3);     // R8 start during read-out
      @(negedge clk);
      start = 1'b0;
      check(in_ready == 1'b0, "R8", "in_ready after busy start", int'(in_ready), 0);
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_bit_q.size() == 0, "R6", "bits still expected",
          exp_bit_q.size(), 0);
    check(busy == 1'b0, "R8", "busy after read-out", int'(busy), 0);
    exp_bit_q.delete();
    exp_last_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R9", "in_ready in reset", int'(in_ready), 0);
    check(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R9", "out_last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);

    try_bad(0);
    try_bad(MAXL + 1);

    run_block(32, 1'b0, 0, 1'b0);   // R4 no padding
    run_block(64, 1'b1, 0, 1'b0);   // R5 no padding, shifted
    run_block(1, 1'b0, 0, 1'b0);    // R1 single bit
    run_block(1, 1'b1, 3, 1'b0);    // R5 single row wrap
    run_block(17, 1'b1, 4, 1'b0);   // R5 R1 wrap inside one row
    run_block(33, 1'b1, 0, 1'b0);   // R1 31 NULLs
    run_block(40, 1'b0, 5, 1'b1);   // R8 starts while busy
    run_block(100, 1'b1, 7, 1'b1);  // R5 R8
    run_block(100, 1'b0, 0, 1'b0);  // R4
    run_block(MAXL, 1'b0, 0, 1'b0); // R4 full size
    run_block(MAXL, 1'b1, 0, 1'b0); // R5 full size wrap
    try_bad(0);                      // R2 after traffic
    report();
  end

endmodule